// File: doc/BRIEF.md
# Slow-Domain Register Access Bridge

The bridge gives a processor on a fast bus clock access to registers in a slow, always-on timekeeping clock domain. The processor never reaches those registers directly. Instead it drives a small window of four word registers: a lane-enable register, a target-address register, a data register and a control register. Software loads the lane enables, the target address and, for a write, the data. It then writes 1 to bit 0 of the control register. The bridge carries the request across the clock boundary and performs exactly one access on a simple slow-side register port. It then reports completion back, clears the busy flag and, for a read, leaves the fetched word in the data register.

The start request crosses into the slow domain as a toggle through a flop synchronizer. Completion returns the same way on a second toggle. The address, lane enables and write data are frozen in holding registers when the request starts and stay stable until the slow side acknowledges. The slow side can therefore sample them without further synchronization. Software must poll control bit 0 until it reads zero before it starts another access.

Top module: `rtc_xbridge`

## Requirements
- R1: After reset all four window registers read zero, busy_o is 0 and no slow-side access is issued.
- R2: Window decode on cpu_addr_i uses word offsets. 0xC is data (32 bits), 0x8 is target address (16 bits, zero-extended), 0x4 is lane enable (8 bits, zero-extended) and 0x0 is control (bit 0 reads busy). An offset with bits 1:0 nonzero selects nothing: it reads zero and its writes change no register.
- R3: Writing a word with bit 0 set to offset 0x0 while idle sets busy_o in the next cycle. busy_o falls again within 100 bus cycles, with no further stimulus.
- R4: When lane-enable bits 3:0 are all zero, the transaction is a read. rtc_we_o stays 0 and the word at the target address lands in the data register.
- R5: When lane-enable bits 3:0 are not all zero, the transaction is a write. rtc_be_o carries bits 3:0, and only the enabled bytes of the target word change (bit n enables bits 8n+7:8n). Lane-enable bits 7:4 have no effect.
- R6: A write to offset 0x0 while busy, or a write there with bit 0 clear, starts nothing.
- R7: While busy, writes to offsets 0x4, 0x8 and 0xC are ignored. Their readback is unchanged and the transaction in flight uses the values captured at start.
- R8: Each accepted start produces exactly one slow-side access: rtc_req_o is high for one slow clock cycle.
- R9: A read result is visible in the data register in the same cycle that busy_o falls. After a write the data register keeps the value software wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Bus-domain asynchronous reset, active low |
| rtc_clk_i | input | 1 | Slow always-on clock |
| rtc_rst_ni | input | 1 | Slow-domain asynchronous reset, active low |
| cpu_req_i | input | 1 | Bus access strobe |
| cpu_we_i | input | 1 | Bus write when high |
| cpu_addr_i | input | 4 | Byte offset into the window |
| cpu_wdata_i | input | 32 | Bus write data |
| cpu_rdata_o | output | 32 | Window readback for cpu_addr_i (combinational) |
| busy_o | output | 1 | Transaction in flight |
| rtc_req_o | output | 1 | One-cycle slow-side access strobe |
| rtc_we_o | output | 1 | Slow-side access is a write |
| rtc_addr_o | output | 16 | Slow-side target address |
| rtc_be_o | output | 4 | Slow-side byte lane enables |
| rtc_wdata_o | output | 32 | Slow-side write data |
| rtc_rdata_i | input | 32 | Slow-side read data, valid while rtc_req_o is high |

## Verification
The bench builds the bridge with its defaults: 32-bit data, a 16-bit target address, an 8-bit lane-enable register and two synchronizer stages. The slow clock runs at one seventh of the bus rate. At that ratio each transaction stays busy for a few dozen bus cycles, which leaves room for the bench to write into the window and to retry a start while busy, and to observe that neither disturbs the access in flight. The four slow-side lanes let the bench try single-byte, mixed and full-word merges. With the 8-bit lane register the upper nibble can be shown to have no effect, including a lane value whose low nibble is zero but whose upper bits are set.

// File: rtl/rtc_xbridge_pkg.sv
package rtc_xbridge_pkg;
  localparam int unsigned OFS_W = 4;
  typedef enum logic [1:0] {
    SLOT_CTL = 2'd0,
    SLOT_BEN = 2'd1,
    SLOT_ADR = 2'd2,
    SLOT_DAT = 2'd3
  } slot_e;
endpackage

// File: rtl/xb_sync.sv
module xb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/xb_cpu_regs.sv
module xb_cpu_regs
  import rtc_xbridge_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RTC_AW = 16,
  parameter int unsigned BE_W   = 8,
  parameter int unsigned LANES  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [OFS_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ack_sync_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              req_tgl_o,
  output logic              busy_o,
  output logic [RTC_AW-1:0] hold_addr_o,
  output logic [LANES-1:0]  hold_be_o,
  output logic [DATA_W-1:0] hold_wdata_o
);
  logic [BE_W-1:0]   be_q;
  logic [RTC_AW-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              busy_q, tgl_q, ack_seen_q;
  logic [RTC_AW-1:0] h_addr_q;
  logic [LANES-1:0]  h_be_q;
  logic [DATA_W-1:0] h_wdata_q;

  slot_e slot;
  logic  hit, wr, start, done, h_read;

  assign slot   = slot_e'(addr_i[3:2]);
  assign hit    = (addr_i[1:0] == 2'b00);
  assign wr     = req_i && we_i && hit;
  assign start  = wr && (slot == SLOT_CTL) && wdata_i[0] && !busy_q;
  assign done   = busy_q && (ack_sync_i != ack_seen_q);
  assign h_read = (h_be_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      be_q       <= '0;
      addr_q     <= '0;
      data_q     <= '0;
      busy_q     <= 1'b0;
      tgl_q      <= 1'b0;
      ack_seen_q <= 1'b0;
      h_addr_q   <= '0;
      h_be_q     <= '0;
      h_wdata_q  <= '0;
    end else begin
      ack_seen_q <= ack_sync_i;
      if (start) begin
        busy_q    <= 1'b1;
        tgl_q     <= ~tgl_q;
        h_addr_q  <= addr_q;
        h_be_q    <= be_q[LANES-1:0];
        h_wdata_q <= data_q;
      end
      if (done) begin
        busy_q <= 1'b0;
        if (h_read) data_q <= rd_data_i;
      end
      if (wr && !busy_q) begin
        unique case (slot)
          SLOT_BEN: be_q   <= wdata_i[BE_W-1:0];
          SLOT_ADR: addr_q <= wdata_i[RTC_AW-1:0];
          SLOT_DAT: data_q <= wdata_i;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      unique case (slot)
        SLOT_CTL: rdata_o = DATA_W'(busy_q);
        SLOT_BEN: rdata_o = DATA_W'(be_q);
        SLOT_ADR: rdata_o = DATA_W'(addr_q);
        SLOT_DAT: rdata_o = data_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign req_tgl_o    = tgl_q;
  assign busy_o       = busy_q;
  assign hold_addr_o  = h_addr_q;
  assign hold_be_o    = h_be_q;
  assign hold_wdata_o = h_wdata_q;
endmodule

// File: rtl/xb_rtc_port.sv
module xb_rtc_port #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RTC_AW = 16,
  parameter int unsigned LANES  = DATA_W / 8
) (
  input  logic              rtc_clk_i,
  input  logic              rtc_rst_ni,
  input  logic              req_sync_i,
  input  logic [RTC_AW-1:0] hold_addr_i,
  input  logic [LANES-1:0]  hold_be_i,
  input  logic [DATA_W-1:0] hold_wdata_i,
  output logic              acc_o,
  output logic              we_o,
  output logic [RTC_AW-1:0] addr_o,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] rd_hold_o,
  output logic              ack_tgl_o
);
  logic              seen_q, ack_q;
  logic [DATA_W-1:0] rd_q;
  logic              acc;

  // a new toggle level means one pending access
  assign acc = (req_sync_i != seen_q);

  always_ff @(posedge rtc_clk_i or negedge rtc_rst_ni) begin
    if (!rtc_rst_ni) begin
      seen_q <= 1'b0;
      ack_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      seen_q <= req_sync_i;
      if (acc) begin
        rd_q  <= rdata_i;
        ack_q <= ~ack_q;
      end
    end
  end

  assign acc_o     = acc;
  assign we_o      = acc && (hold_be_i != '0);
  assign addr_o    = hold_addr_i;
  assign be_o      = hold_be_i;
  assign wdata_o   = hold_wdata_i;
  assign rd_hold_o = rd_q;
  assign ack_tgl_o = ack_q;
endmodule

// File: rtl/rtc_xbridge.sv
module rtc_xbridge
  import rtc_xbridge_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned RTC_AW      = 16,
  parameter int unsigned BE_W        = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LANES      = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rtc_clk_i,
  input  logic              rtc_rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [OFS_W-1:0]  cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              busy_o,
  output logic              rtc_req_o,
  output logic              rtc_we_o,
  output logic [RTC_AW-1:0] rtc_addr_o,
  output logic [LANES-1:0]  rtc_be_o,
  output logic [DATA_W-1:0] rtc_wdata_o,
  input  logic [DATA_W-1:0] rtc_rdata_i
);
  logic              req_tgl, req_sync, ack_tgl, ack_sync, busy;
  logic [RTC_AW-1:0] hold_addr;
  logic [LANES-1:0]  hold_be;
  logic [DATA_W-1:0] hold_wdata, rd_hold;

  xb_cpu_regs #(
    .DATA_W (DATA_W),
    .RTC_AW (RTC_AW),
    .BE_W   (BE_W),
    .LANES  (LANES)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (cpu_req_i),
    .we_i         (cpu_we_i),
    .addr_i       (cpu_addr_i),
    .wdata_i      (cpu_wdata_i),
    .rdata_o      (cpu_rdata_o),
    .ack_sync_i   (ack_sync),
    .rd_data_i    (rd_hold),
    .req_tgl_o    (req_tgl),
    .busy_o       (busy),
    .hold_addr_o  (hold_addr),
    .hold_be_o    (hold_be),
    .hold_wdata_o (hold_wdata)
  );

  xb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i  (rtc_clk_i),
    .rst_ni (rtc_rst_ni),
    .d_i    (req_tgl),
    .q_o    (req_sync)
  );

  xb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ack_tgl),
    .q_o    (ack_sync)
  );

  xb_rtc_port #(
    .DATA_W (DATA_W),
    .RTC_AW (RTC_AW),
    .LANES  (LANES)
  ) u_port (
    .rtc_clk_i    (rtc_clk_i),
    .rtc_rst_ni   (rtc_rst_ni),
    .req_sync_i   (req_sync),
    .hold_addr_i  (hold_addr),
    .hold_be_i    (hold_be),
    .hold_wdata_i (hold_wdata),
    .acc_o        (rtc_req_o),
    .we_o         (rtc_we_o),
    .addr_o       (rtc_addr_o),
    .be_o         (rtc_be_o),
    .wdata_o      (rtc_wdata_o),
    .rdata_i      (rtc_rdata_i),
    .rd_hold_o    (rd_hold),
    .ack_tgl_o    (ack_tgl)
  );

  assign busy_o = busy;
endmodule

// File: rtl/xb_chk.sv
module xb_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RTC_AW = 16,
  parameter int unsigned LANES  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rtc_clk_i,
  input logic              rtc_rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic [3:0]        cpu_addr_i,
  input logic              cpu_wbit0_i,
  input logic              busy_i,
  input logic              req_tgl_i,
  input logic [RTC_AW-1:0] hold_addr_i,
  input logic [LANES-1:0]  hold_be_i,
  input logic [DATA_W-1:0] hold_wdata_i,
  input logic              rtc_req_i
);
  logic go_req;
  assign go_req = cpu_req_i && cpu_we_i && (cpu_addr_i == 4'h0) && cpu_wbit0_i;

  p_start_sets_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_req && !busy_i |=> busy_i);

  p_no_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(go_req && !busy_i) |=> $stable(req_tgl_i));

  p_hold_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(hold_addr_i) && $stable(hold_be_i) && $stable(hold_wdata_i)));

  p_single_access_r8: assert property (@(posedge rtc_clk_i) disable iff (!rtc_rst_ni)
    rtc_req_i |=> !rtc_req_i);
endmodule

bind rtc_xbridge xb_chk #(
  .DATA_W (DATA_W),
  .RTC_AW (RTC_AW),
  .LANES  (LANES)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rtc_clk_i    (rtc_clk_i),
  .rtc_rst_ni   (rtc_rst_ni),
  .cpu_req_i    (cpu_req_i),
  .cpu_we_i     (cpu_we_i),
  .cpu_addr_i   (cpu_addr_i),
  .cpu_wbit0_i  (cpu_wdata_i[0]),
  .busy_i       (busy),
  .req_tgl_i    (req_tgl),
  .hold_addr_i  (hold_addr),
  .hold_be_i    (hold_be),
  .hold_wdata_i (hold_wdata),
  .rtc_req_i    (rtc_req_o)
);

// File: tb/rtc_xbridge_tb_top.sv
module rtc_xbridge_tb_top;
  localparam logic [3:0] O_CTL = 4'h0, O_BEN = 4'h4, O_ADR = 4'h8, O_DAT = 4'hC;
  localparam int NVEC = 8;
  // {lane enable[7:0], target address[15:0], data[31:0]}
  localparam logic [55:0] VEC [NVEC] = '{
    56'hF1_0003_11223344,
    56'h01_0004_55667788,
    56'h0F_0006_DEADBEEF,
    56'h06_0006_A1B2C3D4,
    56'h00_0007_FFFFFFFF,
    56'hF0_0006_0BADF00D,
    56'h08_000F_99AABBCC,
    56'hFF_0000_CAFEF00D
  };

  logic clk = 1'b0, rtc_clk = 1'b0, rst_n = 1'b0, rtc_rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [3:0]  cpu_addr = 4'h0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        busy, rtc_req, rtc_we;
  logic [15:0] rtc_addr;
  logic [3:0]  rtc_be;
  logic [31:0] rtc_wdata, rtc_rdata;

  logic [31:0] mem [16];
  logic [31:0] exp_mem [16];
  int n_chk = 0, n_fail = 0;
  int n_pulse = 0, n_high = 0, n_wr = 0;
  logic prev_req = 1'b0;

  always #5  clk = ~clk;
  always #35 rtc_clk = ~rtc_clk;

  rtc_xbridge dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rtc_clk_i(rtc_clk), .rtc_rst_ni(rtc_rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata), .busy_o(busy),
    .rtc_req_o(rtc_req), .rtc_we_o(rtc_we), .rtc_addr_o(rtc_addr),
    .rtc_be_o(rtc_be), .rtc_wdata_o(rtc_wdata), .rtc_rdata_i(rtc_rdata)
  );

  function automatic logic [31:0] init_val(int i);
    return 32'hC0DE0000 + 32'(i) * 32'h00010111;
  endfunction

  // slow-side register array
  assign rtc_rdata = mem[rtc_addr[3:0]];
  always @(posedge rtc_clk or negedge rtc_rst_n) begin
    if (!rtc_rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= init_val(i);
    end else if (rtc_req && rtc_we) begin
      for (int b = 0; b < 4; b++)
        if (rtc_be[b]) mem[rtc_addr[3:0]][b*8 +: 8] <= rtc_wdata[b*8 +: 8];
    end
  end

  always @(negedge rtc_clk) begin
    if (rtc_req) n_high++;
    if (rtc_req && !prev_req) n_pulse++;
    if (rtc_req && rtc_we) n_wr++;
    prev_req = rtc_req;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] ofs, input logic [31:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = ofs; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] ofs, output logic [31:0] d);
    @(negedge clk);
    cpu_addr = ofs;
    #1 d = cpu_rdata;
  endtask

  // returns data register at the cycle busy falls and the cycle count
  task automatic wait_idle(output logic [31:0] d, output int cyc);
    cpu_addr = O_DAT;
    cyc = 0;
    d = '0;
    while (cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (!busy) begin
        d = cpu_rdata;
        break;
      end
    end
  endtask

  task automatic txn(input logic [7:0] be, input logic [15:0] a, input logic [31:0] dw,
                     output logic [31:0] d, output int cyc);
    bus_wr(O_BEN, {24'h0, be});
    bus_wr(O_ADR, {16'h0, a});
    bus_wr(O_DAT, dw);
    bus_wr(O_CTL, 32'h1);
    chk(busy == 1'b1, "R3 busy after start", {31'h0, busy}, 32'h1);
    wait_idle(d, cyc);
    chk(cyc < 100, "R3 busy clears", 32'(cyc), 32'd100);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r, d;
    int cyc, p0, w0;
    for (int i = 0; i < 16; i++) exp_mem[i] = init_val(i);
    #100 rst_n = 1'b1; rtc_rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    foreach (VEC[k]) if (k < 4) begin
      bus_rd(4'(k * 4), r);
      chk(r == 32'h0, "R1 window reset", r, 32'h0);
    end
    chk(busy == 1'b0 && n_pulse == 0, "R1 idle after reset", {31'h0, busy}, 32'h0);

    // R2 map readback, misaligned offsets hit nothing
    bus_wr(O_BEN, 32'hFFFF_FFF1);
    bus_wr(O_ADR, 32'hABCD_1234);
    bus_wr(O_DAT, 32'h8765_4321);
    bus_rd(O_BEN, r); chk(r == 32'h0000_00F1, "R2 lane enable", r, 32'hF1);
    bus_rd(O_ADR, r); chk(r == 32'h0000_1234, "R2 address", r, 32'h1234);
    bus_rd(O_DAT, r); chk(r == 32'h8765_4321, "R2 data", r, 32'h87654321);
    bus_wr(4'h9, 32'h0000_0055);
    bus_wr(4'h1, 32'h0000_0001);
    bus_rd(O_ADR, r); chk(r == 32'h0000_1234, "R2 misaligned write ignored", r, 32'h1234);
    bus_rd(4'hD, r);  chk(r == 32'h0, "R2 misaligned read zero", r, 32'h0);
    chk(busy == 1'b0, "R2 misaligned control no start", {31'h0, busy}, 32'h0);

    // R6 control write with bit 0 clear
    bus_wr(O_CTL, 32'hFFFF_FFFE);
    repeat (40) @(negedge clk);
    chk(busy == 1'b0 && n_pulse == 0, "R6 bit0 clear starts nothing", 32'(n_pulse), 32'h0);

    // table walk: R4 R5 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0]  be;
      logic [15:0] a;
      logic [31:0] dw;
      {be, a, dw} = VEC[v];
      p0 = n_pulse; w0 = n_wr;
      txn(be, a, dw, d, cyc);
      repeat (2) @(negedge rtc_clk);
      chk(n_pulse == p0 + 1 && n_high == n_pulse, "R8 one single-cycle access",
          32'(n_pulse - p0), 32'h1);
      if (be[3:0] == 4'h0) begin
        chk(d == exp_mem[a[3:0]], "R4 R9 read data at busy fall", d, exp_mem[a[3:0]]);
        chk(n_wr == w0, "R4 no slow-side write", 32'(n_wr - w0), 32'h0);
      end else begin
        for (int b = 0; b < 4; b++) if (be[b]) exp_mem[a[3:0]][b*8 +: 8] = dw[b*8 +: 8];
        chk(d == dw, "R9 data kept after write", d, dw);
        chk(n_wr == w0 + 1, "R5 one slow-side write", 32'(n_wr - w0), 32'h1);
      end
      txn(8'hF0, a, 32'h0, d, cyc);
      chk(d == exp_mem[a[3:0]], "R5 byte merge readback", d, exp_mem[a[3:0]]);
    end

    // R6 R7 writes while busy
    p0 = n_pulse;
    bus_wr(O_BEN, 32'h0000_000F);
    bus_wr(O_ADR, 32'h0000_0005);
    bus_wr(O_DAT, 32'h1357_9BDF);
    bus_wr(O_CTL, 32'h1);
    bus_wr(O_CTL, 32'h1);
    bus_wr(O_ADR, 32'h0000_0009);
    bus_wr(O_BEN, 32'h0000_0000);
    bus_wr(O_DAT, 32'h2468_ACE0);
    chk(busy == 1'b1, "R7 still busy during writes", {31'h0, busy}, 32'h1);
    bus_rd(O_ADR, r); chk(r == 32'h5, "R7 address frozen", r, 32'h5);
    bus_rd(O_BEN, r); chk(r == 32'hF, "R7 lane enable frozen", r, 32'hF);
    bus_rd(O_DAT, r); chk(r == 32'h1357_9BDF, "R7 data frozen", r, 32'h13579BDF);
    wait_idle(d, cyc);
    exp_mem[5] = 32'h1357_9BDF;
    repeat (4) @(negedge rtc_clk);
    chk(n_pulse == p0 + 1, "R6 restart while busy ignored", 32'(n_pulse - p0), 32'h1);
    txn(8'h00, 16'h5, 32'h0, d, cyc);
    chk(d == exp_mem[5], "R7 original target written", d, exp_mem[5]);
    txn(8'h00, 16'h9, 32'h0, d, cyc);
    chk(d == exp_mem[9], "R7 late target untouched", d, exp_mem[9]);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule